// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, at each instruction boundary, whether an interrupt is to be taken and which one. It then walks the processor through entry into the handler. Four kinds of request compete:

- a non-maskable line that reacts to a rising edge;
- a maskable line that reacts to its level and is gated by the interrupt-enable flag;
- a single-step trap raised by the trap flag;
- software requests raised by the instruction being retired.

The execution core pulses `boundary` when an instruction completes and presents its current flag word. For the chosen source, the sequencer does the following in order:

1. For the maskable line only, it runs an acknowledge handshake to fetch the type byte.
2. It emits a push strobe carrying the flag word to be saved.
3. It emits the type number, the vector-table address and the updated flag word, with single-step and interrupt-enable both cleared.

The stack memory and the vector-table read are left to the surrounding core. The two request lines pass through an internal synchronizer before they are used.

Top module: `irq_vector_seq`

## Requirements
- R1: A low-to-high transition of `nmi_in` marks the non-maskable request pending. It stays pending after `nmi_in` falls again and is cleared only when it is serviced. A level held high is therefore serviced once.
- R2: The non-maskable request enters with type 2 and vector address 0x008. Every entry reports `vec_addr` equal to four times `vec_type`.
- R3: `intr_in` is ignored while the interrupt-enable flag (bit 9 of `flags_in`) is clear.
- R4: At a boundary the order of precedence is: software request first, then non-maskable, then maskable, then single-step.
- R5: For a maskable entry, `ack` rises one cycle after the boundary and stays high until `type_valid` is seen. The type is taken from `type_in` in that cycle, and no acknowledge occurs for any other source.
- R6: When the trap flag (bit 8 of `flags_in`) is set at a boundary and no other source wins, a type 1 entry follows.
- R7: `sw_kind` selects the software request:
  - code 0: type `sw_type`;
  - code 1: breakpoint, type 3;
  - code 2: overflow check, type 4 when the overflow flag (bit 11) is set, otherwise no software request.
- R8: Every entry produces one `push` cycle with `push_flags` equal to the boundary's flag word. This is followed in the next cycle by one `vec_valid` cycle, whose `new_flags` is that word with bits 8 and 9 cleared. For non-maskable, software and step entries, `push` occurs in the cycle after the boundary.
- R9: A `boundary` strobe arriving while an entry is in progress (`busy` high) is ignored.
- R10: A synchronous active-high `rst` drops all outputs low and discards a captured non-maskable edge.
- R11: No entry starts without a `boundary` strobe, however long a request has been pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boundary | input | 1 | Instruction-boundary strobe |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| intr_in | input | 1 | Maskable request, level sensitive |
| sw_req | input | 1 | Software interrupt requested by the retiring instruction |
| sw_kind | input | 2 | 0 numbered, 1 breakpoint, 2 overflow check |
| sw_type | input | 8 | Type for a numbered software interrupt |
| flags_in | input | 16 | Current flag word |
| type_valid | input | 1 | Type byte present during acknowledge |
| type_in | input | 8 | Type byte returned during acknowledge |
| busy | output | 1 | Entry sequence in progress |
| ack | output | 1 | Interrupt acknowledge |
| push | output | 1 | Push strobe for the saved flags |
| push_flags | output | 16 | Flag word to be pushed |
| vec_valid | output | 1 | Type, vector address and new flags valid |
| vec_type | output | 8 | Type number of the entry |
| vec_addr | output | 10 | Vector-table address |
| new_flags | output | 16 | Flag word for the handler |

## Verification
The case where two functions collide is a boundary that finds several sources asserted together. Arbitration must then pick one source and also leave the losers' state intact. The bench provokes this with a captured non-maskable edge coinciding with a high, enabled maskable line, and with software, maskable and trap requests presented at the same boundary. Each such case is judged by the reported type and by whether an acknowledge appeared. The bench also places a second boundary, carrying a software request, inside an acknowledge that is still waiting. It then checks that the type that completes is the acknowledged one and that nothing further starts.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int TYPE_W  = 8;
  localparam int FLAG_W  = 16;
  localparam int TF_BIT  = 8;
  localparam int IF_BIT  = 9;
  localparam int OF_BIT  = 11;

  localparam logic [TYPE_W-1:0] T_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] T_NMI  = 8'd2;
  localparam logic [TYPE_W-1:0] T_BRK  = 8'd3;
  localparam logic [TYPE_W-1:0] T_OVF  = 8'd4;

  localparam logic [1:0] K_NUM = 2'd0;
  localparam logic [1:0] K_BRK = 2'd1;
  localparam logic [1:0] K_OVF = 2'd2;

  typedef enum logic [1:0] {SRC_SW, SRC_NMI, SRC_INTR, SRC_STEP} src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_PUSH, ST_VEC} state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr,
  output logic pend
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= lvl;
      if (lvl && !prev) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic              sw_req,
  input  logic [1:0]        sw_kind,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              nmi_pend,
  input  logic              intr_lvl,
  input  logic [FLAG_W-1:0] flags,
  output logic              take,
  output src_e              src,
  output logic [TYPE_W-1:0] typ
);
  logic              sw_hit;
  logic [TYPE_W-1:0] sw_t;

  always_comb begin
    sw_hit = 1'b0;
    sw_t   = sw_type;
    if (sw_req) begin
      case (sw_kind)
        K_NUM: begin sw_hit = 1'b1; sw_t = sw_type; end
        K_BRK: begin sw_hit = 1'b1; sw_t = T_BRK; end
        K_OVF: begin sw_hit = flags[OF_BIT]; sw_t = T_OVF; end
        default: sw_hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    take = 1'b1;
    src  = SRC_SW;
    typ  = sw_t;
    if (sw_hit) begin
      src = SRC_SW;
      typ = sw_t;
    end else if (nmi_pend) begin
      src = SRC_NMI;
      typ = T_NMI;
    end else if (intr_lvl && flags[IF_BIT]) begin
      src = SRC_INTR;
      typ = '0;
    end else if (flags[TF_BIT]) begin
      src = SRC_STEP;
      typ = T_STEP;
    end else begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = TYPE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              nmi_in,
  input  logic              intr_in,
  input  logic              sw_req,
  input  logic [1:0]        sw_kind,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              type_valid,
  input  logic [TYPE_W-1:0] type_in,
  output logic              busy,
  output logic              ack,
  output logic              push,
  output logic [FLAG_W-1:0] push_flags,
  output logic              vec_valid,
  output logic [TYPE_W-1:0] vec_type,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [FLAG_W-1:0] new_flags
);
  localparam logic [FLAG_W-1:0] CLR_MASK = ~((FLAG_W'(1) << TF_BIT) | (FLAG_W'(1) << IF_BIT));

  logic [1:0]        req_sync;
  logic              nmi_s, intr_s, nmi_pend, nmi_clr;
  logic              take;
  src_e              src;
  logic [TYPE_W-1:0] arb_type;
  state_e            state;
  logic [TYPE_W-1:0] ent_type;
  logic [FLAG_W-1:0] ent_flags;
  logic              start;

  irq_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({nmi_in, intr_in}), .q(req_sync)
  );
  assign nmi_s  = req_sync[1];
  assign intr_s = req_sync[0];

  irq_nmi_edge u_edge (
    .clk(clk), .rst(rst), .lvl(nmi_s), .clr(nmi_clr), .pend(nmi_pend)
  );

  irq_arbiter u_arb (
    .sw_req(sw_req), .sw_kind(sw_kind), .sw_type(sw_type),
    .nmi_pend(nmi_pend), .intr_lvl(intr_s), .flags(flags_in),
    .take(take), .src(src), .typ(arb_type)
  );

  assign start   = (state == ST_IDLE) && boundary && take;
  assign nmi_clr = start && (src == SRC_NMI);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ack        <= 1'b0;
      push       <= 1'b0;
      push_flags <= '0;
      vec_valid  <= 1'b0;
      vec_type   <= '0;
      vec_addr   <= '0;
      new_flags  <= '0;
      ent_type   <= '0;
      ent_flags  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          vec_valid <= 1'b0;
          if (start) begin
            ent_flags <= flags_in;
            ent_type  <= arb_type;
            if (src == SRC_INTR) begin
              state <= ST_ACK;
              ack   <= 1'b1;
            end else begin
              state      <= ST_PUSH;
              push       <= 1'b1;
              push_flags <= flags_in;
            end
          end
        end
        ST_ACK: begin
          if (type_valid) begin
            ent_type   <= type_in;
            ack        <= 1'b0;
            state      <= ST_PUSH;
            push       <= 1'b1;
            push_flags <= ent_flags;
          end
        end
        ST_PUSH: begin
          push      <= 1'b0;
          state     <= ST_VEC;
          vec_valid <= 1'b1;
          vec_type  <= ent_type;
          vec_addr  <= {ent_type, 2'b00};
          new_flags <= ent_flags & CLR_MASK;
        end
        default: begin
          vec_valid <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_seq_chk.sv
module irq_vector_seq_chk (
  input logic clk,
  input logic rst,
  input logic boundary,
  input logic type_valid,
  input logic busy,
  input logic ack,
  input logic push,
  input logic vec_valid
);
  p_push_then_vec_r8: assert property (@(posedge clk) disable iff (rst)
    push |=> vec_valid);

  p_single_phase_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack, push, vec_valid}));

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && !type_valid) |=> ack);

  p_ack_to_push_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> push);

  p_start_on_boundary_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(boundary));

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !ack && !push && !vec_valid));
endmodule

bind irq_vector_seq irq_vector_seq_chk u_chk (
  .clk(clk), .rst(rst), .boundary(boundary), .type_valid(type_valid),
  .busy(busy), .ack(ack), .push(push), .vec_valid(vec_valid)
);

// File: tb/irq_vector_seq_bench.sv
module irq_vector_seq_bench;
  logic        clk = 1'b0;
  logic        rst, boundary, nmi_in, intr_in, sw_req, type_valid;
  logic [1:0]  sw_kind;
  logic [7:0]  sw_type, type_in;
  logic [15:0] flags_in;
  logic        busy, ack, push, vec_valid;
  logic [15:0] push_flags, new_flags;
  logic [7:0]  vec_type;
  logic [9:0]  vec_addr;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  irq_vector_seq u_irq_vector_seq (
    .clk(clk), .rst(rst), .boundary(boundary), .nmi_in(nmi_in), .intr_in(intr_in),
    .sw_req(sw_req), .sw_kind(sw_kind), .sw_type(sw_type), .flags_in(flags_in),
    .type_valid(type_valid), .type_in(type_in), .busy(busy), .ack(ack), .push(push),
    .push_flags(push_flags), .vec_valid(vec_valid), .vec_type(vec_type),
    .vec_addr(vec_addr), .new_flags(new_flags)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // {sw_req, sw_kind, sw_type, nmi, intr, flags, ack type, taken, exp type}
  localparam int NV = 12;
  localparam logic [45:0] TBL [NV] = '{
    {1'b1, 2'd0, 8'h21, 1'b0, 1'b1, 16'h0200, 8'h00, 1'b1, 8'h21}, // R4 sw over intr
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b1, 8'h02}, // R1 R2 nmi
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 16'h0200, 8'h00, 1'b1, 8'h02}, // R4 nmi over intr
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 16'h0200, 8'h40, 1'b1, 8'h40}, // R5 maskable
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b0, 8'h00}, // R3 masked
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 16'h0100, 8'h00, 1'b1, 8'h01}, // R6 step
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 16'h0300, 8'h08, 1'b1, 8'h08}, // R4 intr over step
    {1'b1, 2'd1, 8'h77, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 8'h03}, // R7 breakpoint
    {1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 16'h0800, 8'h00, 1'b1, 8'h04}, // R7 overflow set
    {1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00}, // R7 overflow clear
    {1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 16'h0100, 8'h00, 1'b1, 8'h01}, // R7 falls to step
    {1'b1, 2'd0, 8'hFF, 1'b0, 1'b0, 16'h0FFF, 8'h00, 1'b1, 8'hFF}  // R2 R8 top type
  };

  task automatic pulse_boundary();
    @(negedge clk) boundary = 1'b1;
    @(negedge clk) boundary = 1'b0; sw_req = 1'b0;
  endtask

  task automatic run_entry(input logic [15:0] fl, input logic [7:0] aty, input bit taken,
                           input logic [7:0] ety, input bit is_intr);
    bit saw_ack = 0, saw_push = 0, saw_vec = 0;
    bit push_early = 0;
    logic [15:0] pf = '0;
    pulse_boundary();
    push_early = push;
    for (int i = 0; i < 20; i++) begin
      if (ack) begin saw_ack = 1; type_valid = 1'b1; type_in = aty; end
      else type_valid = 1'b0;
      if (push) begin saw_push = 1; pf = push_flags; end
      if (vec_valid) begin
        saw_vec = 1;
        chk(vec_type == ety, "R4 R7 type", vec_type, ety);
        chk(vec_addr == {ety, 2'b00}, "R2 vector address", vec_addr, {ety, 2'b00});
        chk(new_flags == (fl & 16'hFCFF), "R8 new flags", new_flags, fl & 16'hFCFF);
        break;
      end
      @(negedge clk);
    end
    type_valid = 1'b0;
    chk(saw_vec == taken, "R3 R7 entry taken", saw_vec, taken);
    if (taken) begin
      chk(saw_push && pf == fl, "R8 pushed flags", pf, fl);
      chk(saw_ack == is_intr, "R5 acknowledge only for maskable", saw_ack, is_intr);
      if (!is_intr) chk(push_early, "R8 push one cycle after boundary", push_early, 1);
    end
    repeat (2) @(negedge clk);
    chk(!busy, "R9 back to idle", busy, 0);
  endtask

  initial begin
    rst = 1'b1; boundary = 0; nmi_in = 0; intr_in = 0; sw_req = 0; sw_kind = 0;
    sw_type = 0; flags_in = 0; type_valid = 0; type_in = 0;
    repeat (5) @(negedge clk);
    chk(!busy && !ack && !push && !vec_valid, "R10 reset outputs", {busy, ack, push, vec_valid}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [45:0] e = TBL[v];
      sw_req = e[45]; sw_kind = e[44:43]; sw_type = e[42:35];
      intr_in = e[33]; flags_in = e[32:17];
      if (e[34]) begin
        nmi_in = 1'b1; repeat (2) @(negedge clk); nmi_in = 1'b0;
      end
      repeat (5) @(negedge clk);
      chk(!busy, "R11 no entry before boundary", busy, 0);
      run_entry(e[32:17], e[16:9], e[8], e[7:0],
                e[8] && !e[45] && !e[34] && e[33] && e[26]);
      intr_in = 1'b0; sw_req = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R1: held-high level is serviced once only
    flags_in = 16'h0000; nmi_in = 1'b1;
    repeat (5) @(negedge clk);
    run_entry(16'h0000, 8'h00, 1'b1, 8'h02, 1'b0);
    run_entry(16'h0000, 8'h00, 1'b0, 8'h00, 1'b0);
    nmi_in = 1'b0;
    repeat (4) @(negedge clk);

    // R10: reset discards a captured edge
    nmi_in = 1'b1; repeat (2) @(negedge clk); nmi_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1; repeat (4) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    run_entry(16'h0000, 8'h00, 1'b0, 8'h00, 1'b0);

    // R9: boundary with software request during a waiting acknowledge
    intr_in = 1'b1; flags_in = 16'h0200;
    repeat (5) @(negedge clk);
    pulse_boundary();
    chk(ack, "R5 ack after boundary", ack, 1);
    repeat (2) @(negedge clk);
    chk(ack, "R5 ack held while waiting", ack, 1);
    sw_req = 1'b1; sw_kind = 2'd0; sw_type = 8'h55;
    pulse_boundary();
    type_valid = 1'b1; type_in = 8'h30;
    @(negedge clk) type_valid = 1'b0;
    chk(push, "R5 push after type", push, 1);
    @(negedge clk);
    chk(vec_valid && vec_type == 8'h30, "R9 acknowledged type kept", vec_type, 8'h30);
    intr_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !push && !vec_valid, "R9 second boundary ignored", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule